// File: doc/BRIEF.md
# Prioritised Exception Vector Unit

This unit arbitrates among seven kinds of exception request raised in the same clock cycle. It chooses the single winner under a fixed priority order. For that winner it produces the address the core must branch to, the processor mode to enter, an identifier for the exception that was taken, and a one-cycle take strobe. A request for a fast or normal interrupt can be masked. A masked request drops out of arbitration, so a lower-ranked request can win instead. A base-select input moves every vector from the bottom of the address space to the high base.

All outputs are registered and follow the inputs sampled at a clock edge by one cycle. A small controller tracks three named states:
- `ST_RESET`: reset is held.
- `ST_TAKE`: the previous edge saw an unmasked request.
- `ST_IDLE`: the previous edge saw no unmasked request.

The transitions are as follows:
- Any state moves to `ST_RESET` whenever `rst` is high at an edge.
- Otherwise any state moves to `ST_TAKE` when an unmasked request is present.
- Otherwise any state moves to `ST_IDLE`.

The take strobe is high exactly in `ST_TAKE`. Saving the return link, updating status registers and flushing the pipeline are left to the surrounding core.

Top module: `exv_unit`

## Requirements
- R1: At a clock edge where `rst` is high, the outputs after that edge are as follows, whatever the other requests are: `take` is 0, `exc_id` is 0 (reset), `new_mode` is 3 (supervisor), and `vec_addr` is the reset vector for the current `hivec`.
- R2: Priority from highest to lowest is: reset request, data abort, fast interrupt, normal interrupt, prefetch abort, then undefined instruction and software interrupt.
- R3: When undefined instruction and software interrupt are requested together and nothing of higher priority is present, undefined instruction is taken.
- R4: A fast-interrupt request with `mask_fiq`=1, or a normal-interrupt request with `mask_irq`=1, takes no part in arbitration. A lower-ranked request wins instead. If no other request is present, `take` stays 0.
- R5: After each edge with `rst` low, `take` is 1 for that cycle if and only if at least one unmasked request was present at the edge.
- R6: The `exc_id` codes are: reset 0, undefined 1, software interrupt 2, prefetch abort 3, data abort 4, normal interrupt 6, fast interrupt 7. The vector offset is 4 times the code, so the offsets are 0x00, 0x04, 0x08, 0x0C, 0x10, 0x18 and 0x1C. Offset 0x14 is never output.
- R7: With `hivec`=0 the vector is 0x00000000 plus the offset. With `hivec`=1 the vector is 0xFFFF0000 plus the offset.
- R8: The `new_mode` codes are: supervisor 3 for reset and software interrupt, undefined 5, abort 4 for both aborts, interrupt 2, fast interrupt 1.
- R9: After an edge with `rst` low and no unmasked request, `vec_addr`, `new_mode` and `exc_id` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_rst | input | 1 | Reset exception request |
| req_und | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_dabt | input | 1 | Data abort request |
| req_irq | input | 1 | Normal interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| mask_irq | input | 1 | Masks the normal interrupt request |
| mask_fiq | input | 1 | Masks the fast interrupt request |
| hivec | input | 1 | Selects the high vector base |
| vec_addr | output | 32 | Vector address of the taken exception |
| new_mode | output | 3 | Mode code to enter |
| exc_id | output | 3 | Code of the taken exception |
| take | output | 1 | One-cycle take strobe |

## Verification
The bench targets the pairs whose order is non-obvious:
- Data abort against a fast interrupt. A design that ranked by vector offset would wrongly pick the fast interrupt.
- Prefetch abort against a normal interrupt.
- Undefined instruction against software interrupt.

Masked interrupts are driven alone, to catch a design that still strobes. They are also driven next to a low-ranked request, to catch one that blocks the lower request. Reset is applied with every request and `hivec` set, which exposes a reset that leaks other requests through. Idle cycles follow takes, to catch outputs that drift when nothing wins.

// File: rtl/exv_pkg.sv
package exv_pkg;

    // Exception codes: code * 4 is the vector offset; code 5 is reserved.
    typedef enum logic [2:0] {
        EX_RST  = 3'd0,
        EX_UND  = 3'd1,
        EX_SWI  = 3'd2,
        EX_PABT = 3'd3,
        EX_DABT = 3'd4,
        EX_IRQ  = 3'd6,
        EX_FIQ  = 3'd7
    } exc_e;

    typedef enum logic [2:0] {
        MD_USR = 3'd0,
        MD_FIQ = 3'd1,
        MD_IRQ = 3'd2,
        MD_SVC = 3'd3,
        MD_ABT = 3'd4,
        MD_UND = 3'd5
    } mode_e;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_IDLE  = 2'd1,
        ST_TAKE  = 2'd2
    } st_e;

    localparam int unsigned NUM_KINDS = 7;

endpackage

// File: rtl/exv_prio.sv
module exv_prio
    import exv_pkg::*;
(
    input  logic req_rst,
    input  logic req_und,
    input  logic req_swi,
    input  logic req_pabt,
    input  logic req_dabt,
    input  logic req_irq,
    input  logic req_fiq,
    input  logic mask_irq,
    input  logic mask_fiq,
    output logic win_vld,
    output exc_e win_id
);

    localparam int unsigned N = NUM_KINDS;

    // Requests ordered by rank: index 0 is highest priority.
    logic [N-1:0] ranked;
    exc_e         code_at [N];

    assign ranked = {req_swi, req_und, req_pabt,
                     req_irq & ~mask_irq, req_fiq & ~mask_fiq,
                     req_dabt, req_rst};

    assign code_at[0] = EX_RST;
    assign code_at[1] = EX_DABT;
    assign code_at[2] = EX_FIQ;
    assign code_at[3] = EX_IRQ;
    assign code_at[4] = EX_PABT;
    assign code_at[5] = EX_UND;
    assign code_at[6] = EX_SWI;

    always_comb begin
        win_vld = |ranked;
        win_id  = EX_RST;
        for (int i = N - 1; i >= 0; i--) begin
            if (ranked[i]) win_id = code_at[i];
        end
    end

endmodule

// File: rtl/exv_vec.sv
module exv_vec
    import exv_pkg::*;
#(
    parameter int unsigned       ADDR_W  = 32,
    parameter logic [ADDR_W-1:0] HI_BASE = 32'hFFFF_0000
) (
    input  exc_e              id,
    input  logic              hivec,
    output logic [ADDR_W-1:0] addr,
    output mode_e             mode
);

    localparam int unsigned OFF_W = 5;

    logic [OFF_W-1:0] offset;

    assign offset = {id, 2'b00};
    assign addr   = (hivec ? HI_BASE : '0) | {{(ADDR_W-OFF_W){1'b0}}, offset};

    always_comb begin
        unique case (id)
            EX_RST:  mode = MD_SVC;
            EX_SWI:  mode = MD_SVC;
            EX_UND:  mode = MD_UND;
            EX_PABT: mode = MD_ABT;
            EX_DABT: mode = MD_ABT;
            EX_IRQ:  mode = MD_IRQ;
            EX_FIQ:  mode = MD_FIQ;
            default: mode = MD_SVC;
        endcase
    end

endmodule

// File: rtl/exv_unit.sv
module exv_unit
    import exv_pkg::*;
#(
    parameter int unsigned       ADDR_W  = 32,
    parameter logic [ADDR_W-1:0] HI_BASE = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_rst,
    input  logic              req_und,
    input  logic              req_swi,
    input  logic              req_pabt,
    input  logic              req_dabt,
    input  logic              req_irq,
    input  logic              req_fiq,
    input  logic              mask_irq,
    input  logic              mask_fiq,
    input  logic              hivec,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [2:0]        new_mode,
    output logic [2:0]        exc_id,
    output logic              take
);

    st_e               state_q, state_d;
    logic              win_vld;
    exc_e              win_id, sel_id, id_q;
    logic [ADDR_W-1:0] sel_addr, addr_q;
    mode_e             sel_mode, mode_q;

    exv_prio u_prio (
        .req_rst  (req_rst),
        .req_und  (req_und),
        .req_swi  (req_swi),
        .req_pabt (req_pabt),
        .req_dabt (req_dabt),
        .req_irq  (req_irq),
        .req_fiq  (req_fiq),
        .mask_irq (mask_irq),
        .mask_fiq (mask_fiq),
        .win_vld  (win_vld),
        .win_id   (win_id)
    );

    assign sel_id = rst ? EX_RST : win_id;

    exv_vec #(.ADDR_W(ADDR_W), .HI_BASE(HI_BASE)) u_vec (
        .id    (sel_id),
        .hivec (hivec),
        .addr  (sel_addr),
        .mode  (sel_mode)
    );

    always_comb begin
        if (rst)          state_d = ST_RESET;
        else if (win_vld) state_d = ST_TAKE;
        else              state_d = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk) begin
        unique case (state_d)
            ST_RESET, ST_TAKE: begin
                addr_q <= sel_addr;
                mode_q <= sel_mode;
                id_q   <= sel_id;
            end
            ST_IDLE: begin
                addr_q <= addr_q;
                mode_q <= mode_q;
                id_q   <= id_q;
            end
            default: begin
                addr_q <= sel_addr;
                mode_q <= sel_mode;
                id_q   <= sel_id;
            end
        endcase
    end

    assign take     = (state_q == ST_TAKE);
    assign vec_addr = addr_q;
    assign new_mode = mode_q;
    assign exc_id   = id_q;

endmodule

// File: rtl/exv_unit_chk.sv
module exv_unit_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_rst,
    input logic              req_und,
    input logic              req_swi,
    input logic              req_pabt,
    input logic              req_dabt,
    input logic              req_irq,
    input logic              req_fiq,
    input logic              mask_irq,
    input logic              mask_fiq,
    input logic              hivec,
    input logic [ADDR_W-1:0] vec_addr,
    input logic [2:0]        new_mode,
    input logic [2:0]        exc_id,
    input logic              take
);

    logic live;
    assign live = req_rst | req_und | req_swi | req_pabt | req_dabt
                | (req_irq & ~mask_irq) | (req_fiq & ~mask_fiq);

    p_reset_out_r1: assert property (@(posedge clk)
        rst |=> (!take && exc_id == 3'd0 && new_mode == 3'd3 && vec_addr[4:0] == 5'd0));

    p_dabt_over_fiq_r2: assert property (@(posedge clk) disable iff (rst)
        (req_dabt && !req_rst) |=> (exc_id == 3'd4));

    p_und_over_swi_r3: assert property (@(posedge clk) disable iff (rst)
        (req_und && req_swi && !req_rst && !req_dabt && !req_pabt
         && !(req_fiq && !mask_fiq) && !(req_irq && !mask_irq)) |=> (exc_id == 3'd1));

    p_masked_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (!live) |=> !take);

    p_take_r5: assert property (@(posedge clk) disable iff (rst)
        live |=> take);

    p_no_reserved_r6: assert property (@(posedge clk) disable iff (rst)
        take |-> (vec_addr[4:0] != 5'h14 && vec_addr[1:0] == 2'b00));

    p_high_base_r7: assert property (@(posedge clk) disable iff (rst)
        (live && hivec) |=> (vec_addr[ADDR_W-1:ADDR_W-16] == 16'hFFFF));

    p_mode_map_r8: assert property (@(posedge clk) disable iff (rst)
        (take && exc_id == 3'd6) |-> (new_mode == 3'd2));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !live |=> ($stable(vec_addr) && $stable(exc_id) && $stable(new_mode)));

endmodule

bind exv_unit exv_unit_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_exv_unit.sv
`timescale 1ns/1ps
module tb_exv_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_rst = 0, req_und = 0, req_swi = 0, req_pabt = 0;
    logic        req_dabt = 0, req_irq = 0, req_fiq = 0;
    logic        mask_irq = 0, mask_fiq = 0, hivec = 0;
    logic [31:0] vec_addr;
    logic [2:0]  new_mode, exc_id;
    logic        take;

    int checks = 0;
    int fails  = 0;

    logic [31:0] e_vec  = '0;
    logic [2:0]  e_mode = '0;
    logic [2:0]  e_id   = '0;

    always #2 clk = ~clk;

    exv_unit dut (.*);

    // Expected winner code per R2/R3/R4/R6; 3'd5 means none
    function automatic logic [2:0] f_win();
        if (req_rst)               return 3'd0;
        if (req_dabt)              return 3'd4;
        if (req_fiq && !mask_fiq)  return 3'd7;
        if (req_irq && !mask_irq)  return 3'd6;
        if (req_pabt)              return 3'd3;
        if (req_und)               return 3'd1;
        if (req_swi)               return 3'd2;
        return 3'd5;
    endfunction

    // Mode codes per R8
    function automatic logic [2:0] f_mode(input logic [2:0] id);
        case (id)
            3'd0, 3'd2: return 3'd3;
            3'd1:       return 3'd5;
            3'd3, 3'd4: return 3'd4;
            3'd6:       return 3'd2;
            3'd7:       return 3'd1;
            default:    return 3'd0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_in(input logic [9:0] v);
        {req_rst, req_und, req_swi, req_pabt, req_dabt, req_irq, req_fiq,
         mask_irq, mask_fiq, hivec} = v;
    endtask

    // One cycle: predict from current inputs, clock, then compare
    task automatic step(input string tag);
        logic [2:0] w;
        logic       e_take;
        w = rst ? 3'd0 : f_win();
        e_take = !rst && (w != 3'd5);
        if (rst || e_take) begin
            e_id   = w;
            e_mode = f_mode(w);
            e_vec  = (hivec ? 32'hFFFF_0000 : 32'h0) | {27'd0, w, 2'b00};
        end
        @(posedge clk);
        #1;
        chk({tag, " take"}, take, e_take);
        chk({tag, " id"},   exc_id, e_id);
        chk({tag, " mode"}, new_mode, e_mode);
        chk({tag, " vec"},  vec_addr, e_vec);
        if (take) chk({tag, " R6 reserved"}, (vec_addr[4:0] == 5'h14), 0);
    endtask

    initial begin
        #(4ns * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(20240517);
        // R1: reset with everything asserted and high base
        set_in(10'b1111111001);
        rst = 1'b1;
        step("R1 reset");
        step("R1 reset hold");
        rst = 1'b0;
        // R9: idle after reset
        set_in(10'b0000000000);
        step("R9 idle");
        // R2: data abort beats fast interrupt
        set_in(10'b0000101000);
        step("R2 dabt>fiq");
        // R2: prefetch abort loses to irq
        set_in(10'b0001010000);
        step("R2 irq>pabt");
        // R3: und beats swi
        set_in(10'b0110000000);
        step("R3 und>swi");
        // R4: masked fiq alone, then masked irq, R9 hold
        set_in(10'b0000001010);
        step("R4 masked fiq");
        set_in(10'b0000010100);
        step("R4 masked irq");
        // R4: masked fiq with swi lets swi win
        set_in(10'b0010001010);
        step("R4 swi via mask");
        // R7: high base with fiq, R8 mode
        set_in(10'b0000001001);
        step("R7 R8 fiq hi");
        // R5: reset request alone
        set_in(10'b1000000000);
        step("R5 rst req");
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [9:0] v;
            v = 10'($urandom);
            // Thin out requests so low-ranked kinds win often
            v[9:3] = v[9:3] & 7'($urandom) & 7'($urandom);
            set_in(v);
            rst = ($urandom % 64) == 0;
            step("R2 R5 R6 R7 R8 random");
        end
        rst = 1'b0;
        set_in(10'b0000000000);
        step("R9 final idle");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule